// File: doc/BRIEF.md
# System Bus Configuration Controller

This block holds two byte-wide configuration registers that sit at two adjacent addresses on a simple memory-mapped CPU bus. The first register selects how the external bus is organised: a two-bit bus mode, a two-bit chip-enable window mode and one enable bit per chip-enable line. The second register carries a wait-state code, a CPU clock-source select, a fast-oscillator run bit and a two-bit supply-level code. The block decodes these fields into plain control outputs for the rest of the chip.

The block also paces external bus accesses. When an access starts, it drops its ready output for the number of CPU cycles that the wait code selects, and it ignores any new start until ready returns. It also keeps every interrupt request, the non-maskable one included, away from the CPU until software has written both configuration registers at least once since reset. A build parameter selects single-chip or processor mode. In processor mode a second parameter gives the bus mode that reset loads.

Top module: `sysbus_cfg_ctrl`

## Requirements
- R1: After reset, in processor mode, the first register reads {BOOT_BUS_MODE, 2'b00, 1'b0, 3'b111} (0x47 with the default 64K boot mode) and the second reads 0x00. In single-chip mode the first register reads 0x07.
- R2: A write to BASE_ADDR stores bus mode from bits 7:6, the window mode from bits 5:4 and the line 2/1/0 enables from bits 2:0. Bit 3 always reads 0, so writing 0xFF reads back 0xF7 in processor mode.
- R3: A write to BASE_ADDR+1 stores the wait code from bits 6:5, the clock select from bit 4 (1 = fast oscillator), the fast-oscillator run bit from bit 3 (1 = on) and the supply code from bits 1:0. Bits 7 and 2 read 0, so writing 0xFF reads back 0x7B.
- R4: The bus-mode output follows bits 7:6 of the first register, coded 00 single chip, 01 64K, 10 4M minimum, 11 4M maximum. In single-chip mode it stays 00 and writes to those bits are ignored.
- R5: A chip-enable line works as a strobe (ce_strobe_o bit = 1) only when its enable bit is 1 and the bus mode is 01 (64K). Otherwise it is a plain port output (bit = 0).
- R6: A start with wait code c (00/01/10/11) holds xbus_rdy_o low for exactly 0/1/2/3 cycles, beginning in the cycle after the start is sampled.
- R7: A start that arrives while xbus_rdy_o is low is ignored. It neither extends nor restarts the count.
- R8: irq_o and nmi_o stay 0 until both registers have been written, in either order. After that they pass irq_req_i and nmi_req_i unchanged.
- R9: Once open, the interrupt gate stays open through later bus traffic. Only reset closes it again.
- R10: An access to any address other than the two register addresses reads 0, changes no register and does not count as a register write for the interrupt gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_sel_i | input | 1 | Bus cycle valid |
| reg_wr_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | ADDR_W | Bus address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, 0 when no register is selected |
| xbus_start_i | input | 1 | External access begins this cycle |
| xbus_rdy_o | output | 1 | External bus ready, low while wait states run |
| irq_req_i | input | N_IRQ | Raw maskable interrupt requests |
| nmi_req_i | input | 1 | Raw non-maskable interrupt request |
| irq_o | output | N_IRQ | Gated maskable requests |
| nmi_o | output | 1 | Gated non-maskable request |
| bus_mode_o | output | 2 | Bus-mode field |
| ce_win_o | output | 2 | Chip-enable window mode field |
| ce_strobe_o | output | 3 | Per-line strobe function enable |
| osc_fast_on_o | output | 1 | Fast oscillator run control |
| clk_fast_sel_o | output | 1 | CPU clock source, 1 = fast |
| vlevel_o | output | 2 | Supply-level code |

## Verification
The bench builds two copies side by side on the same bus. One uses the default processor mode with the 64K boot value, so the chip-enable strobes can be switched on. The other is built with SINGLE_CHIP set, so the pinned bus mode and the strobes that stay off are checked under exactly the writes that enable them in the first copy. Both copies use N_IRQ = 4, the default base address and the full two-bit wait code. Every code from no wait to three cycles can therefore be measured, along with a start that arrives while ready is low.

// File: rtl/sysbus_cfg_pkg.sv
package sysbus_cfg_pkg;

  localparam int unsigned CE_LINES = 3;
  localparam int unsigned WAIT_W   = 2;

  typedef enum logic [1:0] {
    BM_SINGLE  = 2'b00,
    BM_64K     = 2'b01,
    BM_4M_MIN  = 2'b10,
    BM_4M_MAX  = 2'b11
  } bus_mode_e;

  typedef struct packed {
    bus_mode_e           bm;
    logic [1:0]          win;
    logic                rsv3;
    logic [CE_LINES-1:0] ce_en;
  } cfg_bus_t;

  typedef struct packed {
    logic              rsv7;
    logic [WAIT_W-1:0] wst;
    logic              clk_fast;
    logic              osc_on;
    logic              rsv2;
    logic [1:0]        vlev;
  } cfg_clk_t;

  localparam logic [7:0] RD_MASK_BUS = 8'hF7;
  localparam logic [7:0] RD_MASK_CLK = 8'h7B;

endpackage

// File: rtl/cfg_regs.sv
module cfg_regs
  import sysbus_cfg_pkg::*;
#(
  parameter int unsigned          ADDR_W        = 16,
  parameter logic [ADDR_W-1:0]    BASE_ADDR     = 'hFF00,
  parameter bit                   SINGLE_CHIP   = 1'b0,
  parameter logic [1:0]           BOOT_BUS_MODE = 2'b01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output cfg_bus_t          cfg_bus_o,
  output cfg_clk_t          cfg_clk_o,
  output logic              we_bus_o,
  output logic              we_clk_o
);

  localparam logic [ADDR_W-1:0] ADDR_CLK = BASE_ADDR + 1'b1;
  localparam bus_mode_e BM_RST = SINGLE_CHIP ? BM_SINGLE : bus_mode_e'(BOOT_BUS_MODE);
  localparam cfg_bus_t BUS_RST = '{bm: BM_RST, win: 2'b00, rsv3: 1'b0, ce_en: '1};
  localparam cfg_clk_t CLK_RST = '0;

  logic     hit_bus, hit_clk;
  cfg_bus_t bus_q, bus_d;
  cfg_clk_t clk_q, clk_d;

  assign hit_bus  = sel_i && (addr_i == BASE_ADDR);
  assign hit_clk  = sel_i && (addr_i == ADDR_CLK);
  assign we_bus_o = hit_bus && wr_i;
  assign we_clk_o = hit_clk && wr_i;

  // next-state values for the two registers
  always_comb begin
    bus_d       = bus_q;
    bus_d.bm    = SINGLE_CHIP ? BM_SINGLE : bus_mode_e'(wdata_i[7:6]);
    bus_d.win   = wdata_i[5:4];
    bus_d.rsv3  = 1'b0;
    bus_d.ce_en = wdata_i[CE_LINES-1:0];

    clk_d          = clk_q;
    clk_d.rsv7     = 1'b0;
    clk_d.wst      = wdata_i[6:5];
    clk_d.clk_fast = wdata_i[4];
    clk_d.osc_on   = wdata_i[3];
    clk_d.rsv2     = 1'b0;
    clk_d.vlev     = wdata_i[1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_q <= BUS_RST;
    end else if (we_bus_o) begin
      bus_q <= bus_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_q <= CLK_RST;
    end else if (we_clk_o) begin
      clk_q <= clk_d;
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (hit_bus && !wr_i) rdata_o = bus_q & RD_MASK_BUS;
    if (hit_clk && !wr_i) rdata_o = clk_q & RD_MASK_CLK;
  end

  assign cfg_bus_o = bus_q;
  assign cfg_clk_o = clk_q;

  // write to the clock register lands in the wait field one cycle later
  p_wait_field_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_clk_o |=> (cfg_clk_o.wst == $past(wdata_i[6:5])));

  // writes that miss the first register leave it untouched
  p_bus_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_bus_o |=> $stable(cfg_bus_o));

  if (SINGLE_CHIP) begin : g_sc_chk
    p_bm_pinned_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_bus_o |=> (cfg_bus_o.bm == BM_SINGLE));
  end

endmodule

// File: rtl/xbus_wait_gen.sv
module xbus_wait_gen #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] code_i,
  input  logic             start_i,
  output logic             rdy_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy;

  assign busy = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (busy)         cnt_d = cnt_q - 1'b1;
    else if (start_i) cnt_d = code_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign rdy_o = !busy;

  p_launch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_o && start_i && code_i != '0) |=> !rdy_o);

  p_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_W'(1)) |=> rdy_o);

  // a start during wait states must not shorten or restart the count
  p_busy_ignore_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdy_o && start_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int unsigned N_IRQ = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_bus_i,
  input  logic             we_clk_i,
  input  logic [N_IRQ-1:0] irq_req_i,
  input  logic             nmi_req_i,
  output logic [N_IRQ-1:0] irq_o,
  output logic             nmi_o
);

  logic seen_bus_q, seen_clk_q;
  logic open;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       seen_bus_q <= 1'b0;
    else if (we_bus_i) seen_bus_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       seen_clk_q <= 1'b0;
    else if (we_clk_i) seen_clk_q <= 1'b1;
  end

  assign open  = seen_bus_q && seen_clk_q;
  assign irq_o = irq_req_i & {N_IRQ{open}};
  assign nmi_o = nmi_req_i & open;

  p_sticky_bus_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_bus_q |=> seen_bus_q);

  p_sticky_clk_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_clk_q |=> seen_clk_q);

  // the gate can only open on the edge that follows a register write
  p_open_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open) |-> $past(we_bus_i || we_clk_i));

endmodule

// File: rtl/sysbus_cfg_ctrl.sv
module sysbus_cfg_ctrl
  import sysbus_cfg_pkg::*;
#(
  parameter int unsigned       ADDR_W        = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR     = 'hFF00,
  parameter int unsigned       N_IRQ         = 4,
  parameter bit                SINGLE_CHIP   = 1'b0,
  parameter logic [1:0]        BOOT_BUS_MODE = 2'b01
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_sel_i,
  input  logic                reg_wr_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [7:0]          reg_wdata_i,
  output logic [7:0]          reg_rdata_o,
  input  logic                xbus_start_i,
  output logic                xbus_rdy_o,
  input  logic [N_IRQ-1:0]    irq_req_i,
  input  logic                nmi_req_i,
  output logic [N_IRQ-1:0]    irq_o,
  output logic                nmi_o,
  output logic [1:0]          bus_mode_o,
  output logic [1:0]          ce_win_o,
  output logic [CE_LINES-1:0] ce_strobe_o,
  output logic                osc_fast_on_o,
  output logic                clk_fast_sel_o,
  output logic [1:0]          vlevel_o
);

  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  cfg_bus_t   cfg_bus;
  cfg_clk_t   cfg_clk;
  logic       we_bus, we_clk;
  logic       strobe_mode;

  // assert asynchronously, release on the second clock edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  cfg_regs #(
    .ADDR_W        (ADDR_W),
    .BASE_ADDR     (BASE_ADDR),
    .SINGLE_CHIP   (SINGLE_CHIP),
    .BOOT_BUS_MODE (BOOT_BUS_MODE)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .sel_i     (reg_sel_i),
    .wr_i      (reg_wr_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .cfg_bus_o (cfg_bus),
    .cfg_clk_o (cfg_clk),
    .we_bus_o  (we_bus),
    .we_clk_o  (we_clk)
  );

  xbus_wait_gen #(.CNT_W(WAIT_W)) u_wait (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .code_i  (cfg_clk.wst),
    .start_i (xbus_start_i),
    .rdy_o   (xbus_rdy_o)
  );

  irq_gate #(.N_IRQ(N_IRQ)) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .we_bus_i  (we_bus),
    .we_clk_i  (we_clk),
    .irq_req_i (irq_req_i),
    .nmi_req_i (nmi_req_i),
    .irq_o     (irq_o),
    .nmi_o     (nmi_o)
  );

  assign strobe_mode = (cfg_bus.bm == BM_64K);

  for (genvar i = 0; i < CE_LINES; i++) begin : g_ce
    assign ce_strobe_o[i] = cfg_bus.ce_en[i] & strobe_mode;
  end

  assign bus_mode_o     = cfg_bus.bm;
  assign ce_win_o       = cfg_bus.win;
  assign osc_fast_on_o  = cfg_clk.osc_on;
  assign clk_fast_sel_o = cfg_clk.clk_fast;
  assign vlevel_o       = cfg_clk.vlev;

  p_port_fallback_r5: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (bus_mode_o != BM_64K) |-> (ce_strobe_o == '0));

endmodule

// File: tb/sysbus_cfg_ctrl_tb.sv
module sysbus_cfg_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] A_BUS = 16'hFF00;
  localparam logic [15:0] A_CLK = 16'hFF01;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, wr = 1'b0, start = 1'b0, nmi_req = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [3:0] irq_req = '0;

  logic [7:0] rdata, rdata_sc;
  logic       rdy, rdy_sc, nmi, nmi_sc, osc, osc_sc, cks, cks_sc;
  logic [3:0] irq, irq_sc;
  logic [1:0] bm, bm_sc, win, win_sc, vl, vl_sc;
  logic [2:0] ce, ce_sc;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  // behavioural model state
  logic [7:0] m_r0 = 8'h47, m_r1 = 8'h00;
  int         m_cnt = 0, m_rs = 0;
  bit         m_f0 = 0, m_f1 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysbus_cfg_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_sel_i(sel), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .xbus_start_i(start), .xbus_rdy_o(rdy),
    .irq_req_i(irq_req), .nmi_req_i(nmi_req), .irq_o(irq), .nmi_o(nmi),
    .bus_mode_o(bm), .ce_win_o(win), .ce_strobe_o(ce), .osc_fast_on_o(osc),
    .clk_fast_sel_o(cks), .vlevel_o(vl));

  sysbus_cfg_ctrl #(.SINGLE_CHIP(1'b1)) dut_sc_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_sel_i(sel), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata_sc), .xbus_start_i(start), .xbus_rdy_o(rdy_sc),
    .irq_req_i(irq_req), .nmi_req_i(nmi_req), .irq_o(irq_sc), .nmi_o(nmi_sc),
    .bus_mode_o(bm_sc), .ce_win_o(win_sc), .ce_strobe_o(ce_sc), .osc_fast_on_o(osc_sc),
    .clk_fast_sel_o(cks_sc), .vlevel_o(vl_sc));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // model update on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_rs = 0; m_r0 = 8'h47; m_r1 = 8'h00; m_cnt = 0; m_f0 = 0; m_f1 = 0;
    end else begin
      if (m_rs < 2) begin
        m_rs++; m_r0 = 8'h47; m_r1 = 8'h00; m_cnt = 0; m_f0 = 0; m_f1 = 0;
      end else begin
        if (m_cnt != 0)  m_cnt--;
        else if (start)  m_cnt = int'(m_r1[6:5]);
        if (sel && wr && addr == A_BUS) begin m_r0 = wdata & 8'hF7; m_f0 = 1; end
        if (sel && wr && addr == A_CLK) begin m_r1 = wdata & 8'h7B; m_f1 = 1; end
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [7:0] e_rd, e_rd_sc;
      bit open;
      open = m_f0 && m_f1;
      e_rd = 8'h00; e_rd_sc = 8'h00;
      if (sel && !wr && addr == A_BUS) begin e_rd = m_r0; e_rd_sc = m_r0 & 8'h37; end
      if (sel && !wr && addr == A_CLK) begin e_rd = m_r1; e_rd_sc = m_r1; end
      chk("R2/R3/R10 rdata", rdata, e_rd);
      chk("R1/R4/R10 rdata single-chip", rdata_sc, e_rd_sc);
      chk("R4 bus mode", bm, m_r0[7:6]);
      chk("R4 bus mode single-chip", bm_sc, 2'b00);
      chk("R2 window", win, m_r0[5:4]);
      chk("R5 strobes", ce, (m_r0[7:6] == 2'b01) ? m_r0[2:0] : 3'b000);
      chk("R5 strobes single-chip", ce_sc, 3'b000);
      chk("R3 osc", osc, m_r1[3]);
      chk("R3 clksel", cks, m_r1[4]);
      chk("R3 vlevel", vl, m_r1[1:0]);
      chk("R6 ready", rdy, m_cnt == 0);
      chk("R6 ready single-chip", rdy_sc, m_cnt == 0);
      chk("R8 irq", irq, open ? irq_req : 4'h0);
      chk("R8 nmi", nmi, open ? nmi_req : 1'b0);
      chk("R8 nmi single-chip", nmi_sc, open ? nmi_req : 1'b0);
    end
  end

  task automatic do_reset();
    @(posedge clk); #1 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #1 sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 sel = 1'b0; wr = 1'b0; wdata = 8'h00;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [7:0] d, output logic [7:0] dsc);
    @(posedge clk); #1 sel = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk); d = rdata; dsc = rdata_sc;
    @(posedge clk); #1 sel = 1'b0;
  endtask

  task automatic measure_wait(input int hold, output int lows);
    @(posedge clk); #1 start = 1'b1;
    repeat (hold) @(posedge clk);
    #1 start = 1'b0;
    lows = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (!rdy) lows++;
    end
    // cycles of the start window itself
    lows += (hold > 1) ? hold - 1 : 0;
  endtask

  initial begin
    logic [7:0] d, dsc;
    int lows;
    irq_req = 4'hA; nmi_req = 1'b1;
    do_reset();
    // R1 reset values
    bus_rd(A_BUS, d, dsc);
    chk("R1 first register reset", d, 8'h47);
    chk("R1 first register reset single-chip", dsc, 8'h07);
    bus_rd(A_CLK, d, dsc);
    chk("R1 second register reset", d, 8'h00);
    chk("R8 nmi blocked after reset", nmi, 1'b0);

    // R10 then R8, order: second register first
    bus_wr(16'hFF02, 8'hFF);
    @(negedge clk);
    chk("R10 stray write keeps gate closed", nmi, 1'b0);
    bus_rd(16'hFF02, d, dsc);
    chk("R10 stray read", d, 8'h00);
    bus_wr(A_CLK, 8'h00);
    @(negedge clk);
    chk("R8 one register written", nmi, 1'b0);
    bus_wr(A_BUS, 8'h47);
    @(negedge clk);
    chk("R8 gate open nmi", nmi, 1'b1);
    chk("R8 gate open irq", irq, 4'hA);
    irq_req = 4'h5;
    @(negedge clk);
    chk("R8 irq passthrough", irq, 4'h5);

    // R2 / R4 / R5 bus field patterns
    for (int b = 0; b < 4; b++) begin
      bus_wr(A_BUS, {b[1:0], 6'b111101});
      bus_rd(A_BUS, d, dsc);
      chk("R2 readback", d, {b[1:0], 6'b110101});
      chk("R4 single-chip ignores bus mode", dsc, 8'h35);
      chk("R5 strobe select", ce, (b == 1) ? 3'b101 : 3'b000);
    end
    bus_wr(A_BUS, 8'hFF);
    bus_rd(A_BUS, d, dsc);
    chk("R2 bit3 reads zero", d, 8'hF7);
    bus_wr(A_BUS, 8'h40);
    @(negedge clk);
    chk("R5 enables cleared give port outputs", ce, 3'b000);

    // R3 masking
    bus_wr(A_CLK, 8'hFF);
    bus_rd(A_CLK, d, dsc);
    chk("R3 reserved bits", d, 8'h7B);
    chk("R3 osc on", osc, 1'b1);
    chk("R3 fast clock", cks, 1'b1);

    // R6 every wait code
    for (int c = 0; c < 4; c++) begin
      bus_wr(A_CLK, {1'b0, c[1:0], 5'b00000});
      measure_wait(1, lows);
      chk("R6 wait cycles", lows, c);
    end
    // R7 start held across the busy window with code 11
    bus_wr(A_CLK, 8'h60);
    measure_wait(3, lows);
    chk("R7 start while busy ignored", lows, 3);

    // R9 gate stays open through traffic
    for (int k = 0; k < 4; k++) bus_wr(A_CLK, 8'h00);
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R9 gate stays open", nmi, 1'b1);

    // reset closes gate; order first register then second
    do_reset();
    @(negedge clk);
    chk("R9 reset closes gate", nmi, 1'b0);
    bus_wr(A_BUS, 8'h47);
    @(negedge clk);
    chk("R8 first register only", nmi, 1'b0);
    bus_wr(A_CLK, 8'h00);
    @(negedge clk);
    chk("R8 opposite order opens", nmi, 1'b1);

    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule